// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when a nonvolatile SRAM copies its contents into the nonvolatile cells (a store) and when it copies them back (a recall). It watches a supply-low comparator, a supply-reset comparator, an open-drain request/busy line that can be pulled low from outside, one-cycle software store and recall triggers, and the write-completion strobe of the SRAM port. From these it produces start pulses for the store and recall engines, a pull-down control for the shared line, and inhibits that the SRAM port uses to gate new writes or all accesses.

A modified flag keeps stores that are requested by hardware or by power loss from running when the array has not been written since the last nonvolatile cycle. Software stores always run. A recall runs by itself after power-up, and again after any dip below the reset level once the supply has recovered. A store requested on the line leaves the device in standby until the line is high again, then a short recovery interval passes before accesses resume. Every duration is a parameter in clock cycles.

Top module: `nvs_sequencer`

## Requirements
- R1: While reset is asserted all outputs are low. A recall is armed by reset, so the first recall begins on the first clock edge after reset once `pwr_low_i` is low.
- R2: A modified flag is set by `wr_done_i` and cleared on the last cycle of any store or recall. A line request after a completed store therefore finds the flag clear and skips its store.
- R3: In idle with the supply good, a low level on `hsb_in_i` opens a grace window of GRACE_CYC cycles. During the window `wr_block_o` is high, `io_block_o` stays low, and the line is not driven.
- R4: A store requested by the line or by power loss runs only if the modified flag is set. A line request that finds the flag clear goes straight to the standby hold.
- R5: A store lasts STORE_CYC cycles. Throughout it `hsb_drive_low_o`, `busy_o` and `io_block_o` are high. `store_start_o` is high for exactly its first cycle.
- R6: After a store or skipped store that was requested by the line, `io_block_o` stays high until `hsb_in_i` is sampled high. RECOVER_CYC further blocked cycles follow, and then idle resumes.
- R7: A rising edge of `pwr_low_i` seen in idle drives the line low for PROBE_CYC cycles. If the flag is set, a store follows. If it is clear, the line is released, no store runs, and the block returns to idle.
- R8: If `hsb_in_i` is still high at the end of the power-loss probe, the store attempt is abandoned and the modified flag is kept.
- R9: A `pwr_rst_i` pulse arms a recall. The recall lasts PU_RECALL_CYC cycles and begins in idle once `pwr_low_i` is low. A supply dip without `pwr_rst_i` starts no recall.
- R10: While `pwr_low_i` is high, `wr_block_o` is high and a low line starts nothing.
- R11: A software store pulse in idle starts a store of STORE_CYC cycles even when the flag is clear, then returns to idle. A software recall pulse starts a recall of SW_RECALL_CYC cycles.
- R12: Priority in idle, highest first: armed recall, power-loss edge, line request, software store, software recall. Triggers that arrive outside idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_low_i | input | 1 | Supply below trigger level |
| pwr_rst_i | input | 1 | Supply below reset level |
| hsb_in_i | input | 1 | Sampled level of the open-drain request/busy line (1 = high) |
| sw_store_i | input | 1 | Software store trigger, one cycle |
| sw_recall_i | input | 1 | Software recall trigger, one cycle |
| wr_done_i | input | 1 | SRAM write completed |
| hsb_drive_low_o | output | 1 | Pull the request/busy line low |
| busy_o | output | 1 | Store or recall engine running |
| wr_block_o | output | 1 | Inhibit new SRAM writes |
| io_block_o | output | 1 | Inhibit all SRAM accesses |
| store_start_o | output | 1 | Store engine start pulse |
| recall_start_o | output | 1 | Recall engine start pulse |

## Verification
The bench targets the skip paths, where a clean array must not start a store. A design that ignored the flag would show an extra store pulse after the second line request and after the clean power-loss probe. It also holds the line high during a power-loss probe. A design that ignored the readback would store anyway and clear the flag. The bench checks that a low line during a supply dip does nothing, and that a dip without a reset pulse brings no recall. A design that missed either would block accesses or pulse the recall engine. Same-cycle line and software triggers show whether the priority order is kept: a wrong order gives a recall pulse where a store is expected.

// File: rtl/nvs_seq_pkg.sv
package nvs_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_GRACE  = 3'd1,
      SQ_STORE  = 3'd2,
      SQ_HOLD   = 3'd3,
      SQ_RECOV  = 3'd4,
      SQ_RECALL = 3'd5
   } seq_state_e;

   typedef enum logic [1:0] {
      ORG_HW = 2'd0,
      ORG_PF = 2'd1,
      ORG_SW = 2'd2
   } origin_e;

endpackage

// File: rtl/nvs_cycle_timer.sv
module nvs_cycle_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load_i)        cnt_q <= load_val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R3: a loaded count must walk down one step per cycle
   a_r3_count_walks: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nvs_dirty_flag.sv
module nvs_dirty_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_done_i,
   input  logic clr_i,
   output logic dirty_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dirty_o <= 1'b0;
      else if (clr_i)     dirty_o <= 1'b0;
      else if (wr_done_i) dirty_o <= 1'b1;
   end

   // R2: the flag is only ever raised by a completed write
   a_r2_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dirty_o) |-> $past(wr_done_i));

endmodule

// File: rtl/nvs_recall_latch.sv
module nvs_recall_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_rst_i,
   input  logic pwr_low_i,
   input  logic take_i,
   output logic pend_o,
   output logic low_rise_o
);
   logic low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= 1'b1;
         low_q  <= 1'b0;
      end else begin
         pend_o <= pwr_rst_i | (pend_o & ~take_i);
         low_q  <= pwr_low_i;
      end
   end

   assign low_rise_o = pwr_low_i & ~low_q;

   // R9: an armed recall stays armed until it is taken
   a_r9_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !take_i) |=> pend_o);

endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer
   import nvs_seq_pkg::*;
#(
   parameter int GRACE_CYC     = 50,
   parameter int PROBE_CYC     = 50,
   parameter int STORE_CYC     = 500000,
   parameter int RECOVER_CYC   = 35,
   parameter int SW_RECALL_CYC = 1000,
   parameter int PU_RECALL_CYC = 27500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_low_i,
   input  logic pwr_rst_i,
   input  logic hsb_in_i,
   input  logic sw_store_i,
   input  logic sw_recall_i,
   input  logic wr_done_i,
   output logic hsb_drive_low_o,
   output logic busy_o,
   output logic wr_block_o,
   output logic io_block_o,
   output logic store_start_o,
   output logic recall_start_o
);
   localparam int M1      = (GRACE_CYC > PROBE_CYC) ? GRACE_CYC : PROBE_CYC;
   localparam int M2      = (STORE_CYC > RECOVER_CYC) ? STORE_CYC : RECOVER_CYC;
   localparam int M3      = (SW_RECALL_CYC > PU_RECALL_CYC) ? SW_RECALL_CYC : PU_RECALL_CYC;
   localparam int M12     = (M1 > M2) ? M1 : M2;
   localparam int MAX_LEN = (M12 > M3) ? M12 : M3;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   localparam logic [CNT_W-1:0] L_GRACE = CNT_W'(GRACE_CYC - 1);
   localparam logic [CNT_W-1:0] L_PROBE = CNT_W'(PROBE_CYC - 1);
   localparam logic [CNT_W-1:0] L_STORE = CNT_W'(STORE_CYC - 1);
   localparam logic [CNT_W-1:0] L_RECOV = CNT_W'(RECOVER_CYC - 1);
   localparam logic [CNT_W-1:0] L_SWRC  = CNT_W'(SW_RECALL_CYC - 1);
   localparam logic [CNT_W-1:0] L_PURC  = CNT_W'(PU_RECALL_CYC - 1);

   generate
      if (GRACE_CYC < 1 || PROBE_CYC < 1 || STORE_CYC < 1 ||
          RECOVER_CYC < 1 || SW_RECALL_CYC < 1 || PU_RECALL_CYC < 1) begin : g_bad_len
         $error("nvs_sequencer: every duration must be at least one cycle");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   origin_e          origin_q, origin_d;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             zero;
   logic             dirty, clr_dirty;
   logic             recall_pend, low_rise, take_recall;
   logic             st_start_d, rc_start_d;
   logic             line_req;

   nvs_cycle_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .zero_o     (zero)
   );

   nvs_dirty_flag u_dirty (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_done_i (wr_done_i),
      .clr_i     (clr_dirty),
      .dirty_o   (dirty)
   );

   nvs_recall_latch u_rlatch (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_rst_i  (pwr_rst_i),
      .pwr_low_i  (pwr_low_i),
      .take_i     (take_recall),
      .pend_o     (recall_pend),
      .low_rise_o (low_rise)
   );

   assign line_req  = ~hsb_in_i & ~pwr_low_i;
   assign clr_dirty = ((state_q == SQ_STORE) || (state_q == SQ_RECALL)) && zero;

   always_comb begin
      state_d     = state_q;
      origin_d    = origin_q;
      load        = 1'b0;
      load_val    = '0;
      st_start_d  = 1'b0;
      rc_start_d  = 1'b0;
      take_recall = 1'b0;
      unique case (state_q)
         SQ_IDLE: begin
            if (recall_pend && !pwr_low_i) begin
               state_d = SQ_RECALL; load = 1'b1; load_val = L_PURC;
               rc_start_d = 1'b1; take_recall = 1'b1;
            end else if (low_rise) begin
               state_d = SQ_GRACE; origin_d = ORG_PF; load = 1'b1; load_val = L_PROBE;
            end else if (line_req) begin
               state_d = SQ_GRACE; origin_d = ORG_HW; load = 1'b1; load_val = L_GRACE;
            end else if (sw_store_i) begin
               state_d = SQ_STORE; origin_d = ORG_SW; load = 1'b1; load_val = L_STORE;
               st_start_d = 1'b1;
            end else if (sw_recall_i) begin
               state_d = SQ_RECALL; load = 1'b1; load_val = L_SWRC;
               rc_start_d = 1'b1;
            end
         end
         SQ_GRACE: begin
            if (zero) begin
               if (origin_q == ORG_HW) begin
                  if (dirty) begin
                     state_d = SQ_STORE; load = 1'b1; load_val = L_STORE; st_start_d = 1'b1;
                  end else begin
                     state_d = SQ_HOLD;
                  end
               end else if (dirty && !hsb_in_i) begin
                  state_d = SQ_STORE; load = 1'b1; load_val = L_STORE; st_start_d = 1'b1;
               end else begin
                  state_d = SQ_IDLE;
               end
            end
         end
         SQ_STORE: begin
            if (zero) state_d = (origin_q == ORG_HW) ? SQ_HOLD : SQ_IDLE;
         end
         SQ_HOLD: begin
            if (hsb_in_i) begin
               state_d = SQ_RECOV; load = 1'b1; load_val = L_RECOV;
            end
         end
         SQ_RECOV: begin
            if (zero) state_d = SQ_IDLE;
         end
         SQ_RECALL: begin
            if (zero) state_d = SQ_IDLE;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q        <= SQ_IDLE;
         origin_q       <= ORG_HW;
         store_start_o  <= 1'b0;
         recall_start_o <= 1'b0;
      end else begin
         state_q        <= state_d;
         origin_q       <= origin_d;
         store_start_o  <= st_start_d;
         recall_start_o <= rc_start_d;
      end
   end

   assign hsb_drive_low_o = (state_q == SQ_STORE) ||
                            ((state_q == SQ_GRACE) && (origin_q == ORG_PF));
   assign busy_o          = (state_q == SQ_STORE) || (state_q == SQ_RECALL);
   assign io_block_o      = (state_q == SQ_STORE) || (state_q == SQ_HOLD) ||
                            (state_q == SQ_RECOV) || (state_q == SQ_RECALL);
   assign wr_block_o      = pwr_low_i || (state_q != SQ_IDLE);

   // R5: start pulses last one cycle and never coincide
   a_r5_store_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      store_start_o |=> !store_start_o);
   a_r9_recall_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      recall_start_o |=> !recall_start_o);
   a_r12_starts_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({store_start_o, recall_start_o}));
   // R5: a store begins with the line driven and accesses blocked
   a_r5_start_drives_line: assert property (@(posedge clk) disable iff (!rst_n)
      store_start_o |-> (hsb_drive_low_o && io_block_o && busy_o));
   // R4: a store not requested by software needs the modified flag
   a_r4_clean_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      (store_start_o && origin_q != ORG_SW) |-> dirty);
   // R6: standby holds while the line stays low
   a_r6_hold_until_high: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_HOLD && !hsb_in_i) |=> (state_q == SQ_HOLD));
   // R8: a probe that reads the line high ends in idle
   a_r8_probe_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_GRACE && origin_q == ORG_PF && zero && hsb_in_i) |=> (state_q == SQ_IDLE));

endmodule

// File: tb/nvs_sequencer_test.sv
module nvs_sequencer_test;
   localparam int G = 4, P = 3, S = 10, RV = 3, RS = 6, RP = 8;
   localparam int M_IDLE = 0, M_GRACE = 1, M_STORE = 2, M_HOLD = 3, M_RECOV = 4, M_RCL = 5;
   localparam int O_HW = 0, O_PF = 1, O_SW = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0, pwr_low = 1'b0, pwr_rst = 1'b0, ext_low = 1'b0, ext_high = 1'b0;
   logic sw_st = 1'b0, sw_rc = 1'b0, wr_done = 1'b0;
   logic drv, busy, wrb, iob, ss, rs;
   logic hsb_line;

   assign hsb_line = ext_high | ~(drv | ext_low);

   nvs_sequencer #(
      .GRACE_CYC(G), .PROBE_CYC(P), .STORE_CYC(S),
      .RECOVER_CYC(RV), .SW_RECALL_CYC(RS), .PU_RECALL_CYC(RP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pwr_low_i(pwr_low), .pwr_rst_i(pwr_rst),
      .hsb_in_i(hsb_line), .sw_store_i(sw_st), .sw_recall_i(sw_rc), .wr_done_i(wr_done),
      .hsb_drive_low_o(drv), .busy_o(busy), .wr_block_o(wrb), .io_block_o(iob),
      .store_start_o(ss), .recall_start_o(rs)
   );

   int compared = 0, mismatched = 0, n_ss = 0, n_rs = 0;
   string phase = "R1";

   // behavioural reference
   int m_st = M_IDLE, m_src = O_HW, m_left = 0;
   bit m_dirty = 0, m_pend = 1, m_plq = 0, m_ss = 0, m_rs = 0;
   bit mdrv, mline, mrise, mdone, mfin, mtook, nss, nrs;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = M_IDLE; m_src = O_HW; m_left = 0; m_dirty = 0;
         m_pend = 1; m_plq = 0; m_ss = 0; m_rs = 0;
      end else begin
         mdrv  = (m_st == M_STORE) || (m_st == M_GRACE && m_src == O_PF);
         mline = ext_high || !(mdrv || ext_low);
         mrise = pwr_low && !m_plq;
         mdone = (m_left == 1);
         mfin  = (m_st == M_STORE || m_st == M_RCL) && mdone;
         mtook = 0; nss = 0; nrs = 0;
         case (m_st)
            M_IDLE: begin
               if (m_pend && !pwr_low) begin m_st = M_RCL; m_left = RP; nrs = 1; mtook = 1; end
               else if (mrise) begin m_st = M_GRACE; m_src = O_PF; m_left = P; end
               else if (!mline && !pwr_low) begin m_st = M_GRACE; m_src = O_HW; m_left = G; end
               else if (sw_st) begin m_st = M_STORE; m_src = O_SW; m_left = S; nss = 1; end
               else if (sw_rc) begin m_st = M_RCL; m_left = RS; nrs = 1; end
            end
            M_GRACE: begin
               if (mdone) begin
                  if (m_src == O_HW) begin
                     if (m_dirty) begin m_st = M_STORE; m_left = S; nss = 1; end
                     else m_st = M_HOLD;
                  end else if (m_dirty && !mline) begin m_st = M_STORE; m_left = S; nss = 1; end
                  else m_st = M_IDLE;
               end else m_left--;
            end
            M_STORE: if (mdone) m_st = (m_src == O_HW) ? M_HOLD : M_IDLE; else m_left--;
            M_HOLD:  if (mline) begin m_st = M_RECOV; m_left = RV; end
            M_RECOV: if (mdone) m_st = M_IDLE; else m_left--;
            M_RCL:   if (mdone) m_st = M_IDLE; else m_left--;
            default: m_st = M_IDLE;
         endcase
         if (mfin) m_dirty = 0; else if (wr_done) m_dirty = 1;
         m_pend = pwr_rst || (m_pend && !mtook);
         m_plq = pwr_low; m_ss = nss; m_rs = nrs;
      end
   end

   function automatic logic [5:0] expect_out();
      logic d;
      d = (m_st == M_STORE) || (m_st == M_GRACE && m_src == O_PF);
      return {d, (m_st == M_STORE || m_st == M_RCL),
              (pwr_low || m_st != M_IDLE),
              (m_st == M_STORE || m_st == M_HOLD || m_st == M_RECOV || m_st == M_RCL),
              m_ss, m_rs};
   endfunction

   task automatic check(string tag, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      compared++;
      if ({drv, busy, wrb, iob, ss, rs} !== expect_out()) begin
         mismatched++;
         $display("FAIL %s: outputs actual=%b expected=%b at %0t", phase,
                  {drv, busy, wrb, iob, ss, rs}, expect_out(), $time);
      end
      if (ss) n_ss++;
      if (rs) n_rs++;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic pulse_wr();
      wr_done = 1'b1; tick(); wr_done = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      // R1: reset state, then the armed power-up recall
      phase = "R1";
      ticks(3);
      check("R1 outputs in reset", int'({drv, busy, wrb, iob, ss, rs}), 0);
      rst_n = 1'b1;
      tick();
      check("R1 recall starts first cycle", int'(rs), 1);
      ticks(12);
      check("R9 power-up recall count", n_rs, 1);

      // R3 R5 R6: line request with a modified array
      phase = "R3";
      pulse_wr();
      ext_low = 1'b1;
      tick();
      check("R3 grace blocks writes", int'(wrb), 1);
      check("R3 grace keeps reads open", int'(iob), 0);
      phase = "R5";
      ticks(25);
      check("R5 store ran", n_ss, 1);
      phase = "R6";
      check("R6 held while line low", int'(iob), 1);
      ext_low = 1'b0;
      ticks(5);
      check("R6 released after recovery", int'(iob), 0);

      // R2 R4: flag cleared by the store, so the next request skips
      phase = "R4";
      ext_low = 1'b1;
      ticks(8);
      check("R2 R4 clean request skipped", n_ss, 1);
      check("R4 skip still holds", int'(iob), 1);
      ext_low = 1'b0;
      ticks(5);

      // R11: software store on a clean array, software recall
      phase = "R11";
      sw_st = 1'b1; tick(); sw_st = 1'b0;
      ticks(12);
      check("R11 software store always runs", n_ss, 2);
      sw_rc = 1'b1; tick(); sw_rc = 1'b0;
      ticks(8);
      check("R11 software recall ran", n_rs, 2);

      // R7: power loss with a modified array
      phase = "R7";
      pulse_wr();
      pwr_low = 1'b1;
      ticks(16);
      check("R7 power-loss store", n_ss, 3);
      pwr_low = 1'b0;
      ticks(2);
      check("R9 dip without reset level no recall", n_rs, 2);

      // R7: power loss with a clean array
      pwr_low = 1'b1;
      tick();
      check("R7 probe drives line", int'(drv), 1);
      ticks(5);
      check("R7 clean probe no store", n_ss, 3);
      pwr_low = 1'b0;
      tick();

      // R8: line held high externally during the probe
      phase = "R8";
      pulse_wr();
      ext_high = 1'b1; pwr_low = 1'b1;
      ticks(6);
      check("R8 store abandoned", n_ss, 3);
      ext_high = 1'b0;

      // R10: supply low blocks writes and line requests
      phase = "R10";
      ext_low = 1'b1;
      ticks(4);
      check("R10 line request ignored", n_ss, 3);
      check("R10 no access block", int'(iob), 0);
      check("R10 writes blocked", int'(wrb), 1);
      ext_low = 1'b0;

      // R9: reset-level dip arms a recall run after recovery
      phase = "R9";
      pwr_rst = 1'b1; tick(); pwr_rst = 1'b0;
      tick();
      pwr_low = 1'b0;
      ticks(10);
      check("R9 recall after reset-level dip", n_rs, 3);

      // R12: same-cycle line and software recall, then a late software store
      phase = "R12";
      pulse_wr();
      ext_low = 1'b1; sw_rc = 1'b1;
      tick();
      sw_rc = 1'b0;
      ticks(2);
      sw_st = 1'b1; tick(); sw_st = 1'b0;
      ticks(20);
      ext_low = 1'b0;
      ticks(5);
      check("R12 line request won", n_ss, 4);
      check("R12 software recall dropped", n_rs, 3);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule